// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block sits on the host side of an external flash device. Once a program or erase command sequence has been sent, it decides whether that operation has finished. A one-cycle `start` pulse begins a poll. The block then issues read cycles to one fixed status address. It compares the toggle flag (data bit 6) across each back-to-back pair of reads, and it watches the time-limit flag (data bit 5) on the second read of each pair.

When the toggle flag stops changing within a pair, the result is a pass. If the flag is still changing when the time-limit flag is seen high, the block runs one more confirming pair. Toggling can stop at the same moment the limit flag rises, so this extra pair is needed. Only if the confirming pair still toggles does the block report failure and write the reset command (data `0xF0`) to a configurable address. A pair-count limit can also end a poll that never settles.

The host may abandon a poll at any point while reads are in progress. The next start then begins again with a fresh pair of reads. The result is reported as a one-cycle `done` pulse with a `pass` flag. `busy` is high from the cycle after `start` until the `done` cycle.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `bus_rd` and `bus_wr` are all low.
- R2: Every read holds `bus_rd` high for exactly `RD_CYC` consecutive cycles with `bus_addr` = `STAT_ADDR`. `bus_rdata` is taken only in the last cycle of the strobe, at least one idle cycle separates reads, and `bus_rd` and `bus_wr` are never high together.
- R3: If data bit 6 is equal in the two reads of a pair, the poll ends with `done`=1 and `pass`=1, and no write is issued.
- R4: If bit 6 differs within a pair and bit 5 of the pair's second read is 0, a new pair of reads follows.
- R5: If bit 6 differs and bit 5 of the second read is 1, one more pair is read. If bit 6 is equal in that pair, the poll passes with no write.
- R6: If bit 6 still differs in that confirming pair, exactly one write of `0xF0` to `RST_ADDR` is issued, followed by `done`=1 with `pass`=0.
- R7: With `MAX_PAIRS` nonzero, a poll whose first `MAX_PAIRS` pairs all toggle ends after `2*MAX_PAIRS` reads with the reset write and `pass`=0. A value of 0 removes the limit.
- R8: `busy` rises in the cycle after an accepted `start`. `done` lasts one cycle with `busy` still high, and `busy` is low in the following cycle.
- R9: `abort` while a poll is reading or between reads returns the block to idle in the next cycle, with no `done` and no write. The next poll starts with a fresh first read and does not reuse the stored bit 6 value.
- R10: `abort` while idle has no effect: no bus cycle, no `done`, `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a poll (accepted when idle) |
| abort | input | 1 | Abandon the poll in progress |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data from flash |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with `done` |

## Verification
The decision logic is driven with several scripted status sequences:
- A steady bit 6 separates the immediate-pass path from everything else.
- A toggling pair with bit 5 low, and then one with bit 5 high, separates plain re-polling from the confirming pair.
- A confirming pair that settles versus one that keeps toggling separates the race-covered pass from true failure and its reset write.
- An endless toggle exercises the pair limit.

The read data is deliberately wrong in every strobe cycle but the last, so early sampling is visible. An abort placed after a differing first read, followed by a steady restart, shows whether a stale toggle value is reused.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_GAP,
    ST_WRITE,
    ST_REPORT
  } poll_st_e;

  localparam logic [7:0] RESET_CMD = 8'hF0;
  localparam int TOGGLE_BIT = 6;
  localparam int LIMIT_BIT  = 5;
endpackage

// File: rtl/poll_strobe_timer.sv
module poll_strobe_timer #(
  parameter int RD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic last
);
  localparam int CW = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign last = en && (cnt_q == CW'(RD_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en || last) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a strobe held for a full window must produce its sampling cycle
  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !last) |=> (!en || (cnt_q != '0) || last));
endmodule

// File: rtl/poll_pair_watch.sv
module poll_pair_watch #(
  parameter int MAX_PAIRS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam bit EN  = (MAX_PAIRS != 0);
  localparam int LIM = EN ? MAX_PAIRS - 1 : 0;
  localparam int CW  = $clog2(MAX_PAIRS + 2);

  logic [CW-1:0] cnt_q, cnt_d;

  assign hit = EN && (cnt_q == CW'(LIM));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                             cnt_d = '0;
    else if (inc && cnt_q != CW'(LIM))   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: a clear always brings the limit flag down unless the limit is one pair
  p_clr_drops_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && LIM != 0) |=> !hit);
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import poll_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] STAT_ADDR = 16'h0000,
  parameter logic [AW-1:0] RST_ADDR  = 16'h0000,
  parameter int          RD_CYC    = 3,
  parameter int          MAX_PAIRS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          pass
);
  poll_st_e state_q, state_d;
  logic     second_q, second_d;
  logic     tog_q, tog_d;
  logic     chk_q, chk_d;
  logic     pass_q, pass_d;
  logic     strobe_last;
  logic     pair_done, wd_clr, wd_hit;
  logic     unused_bits;

  assign unused_bits = ^{bus_rdata[7], bus_rdata[4:0]};

  poll_strobe_timer #(.RD_CYC(RD_CYC)) i_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state_q == ST_READ),
    .last (strobe_last)
  );

  poll_pair_watch #(.MAX_PAIRS(MAX_PAIRS)) i_watch (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (wd_clr),
    .inc  (pair_done),
    .hit  (wd_hit)
  );

  always_comb begin
    state_d   = state_q;
    second_d  = second_q;
    tog_d     = tog_q;
    chk_d     = chk_q;
    pass_d    = pass_q;
    pair_done = 1'b0;
    wd_clr    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_READ;
          second_d = 1'b0;
          chk_d    = 1'b0;
          wd_clr   = 1'b1;
        end
      end
      ST_READ: begin
        if (abort) begin
          state_d  = ST_IDLE;
          second_d = 1'b0;
          chk_d    = 1'b0;
        end else if (strobe_last) begin
          if (!second_q) begin
            tog_d    = bus_rdata[TOGGLE_BIT];
            second_d = 1'b1;
            state_d  = ST_GAP;
          end else begin
            second_d  = 1'b0;
            pair_done = 1'b1;
            if (bus_rdata[TOGGLE_BIT] == tog_q) begin
              pass_d  = 1'b1;
              state_d = ST_REPORT;
            end else if (chk_q || wd_hit) begin
              pass_d  = 1'b0;
              state_d = ST_WRITE;
            end else begin
              chk_d   = bus_rdata[LIMIT_BIT];
              state_d = ST_GAP;
            end
          end
        end
      end
      ST_GAP: begin
        if (abort) begin
          state_d  = ST_IDLE;
          second_d = 1'b0;
          chk_d    = 1'b0;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_WRITE:  state_d = ST_REPORT;
      ST_REPORT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      tog_q    <= 1'b0;
      chk_q    <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      second_q <= second_d;
      tog_q    <= tog_d;
      chk_q    <= chk_d;
      pass_q   <= pass_d;
    end
  end

  assign bus_rd    = (state_q == ST_READ);
  assign bus_wr    = (state_q == ST_WRITE);
  assign bus_addr  = bus_wr ? RST_ADDR : STAT_ADDR;
  assign bus_wdata = bus_wr ? RESET_CMD : 8'h00;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_REPORT);
  assign pass      = done && pass_q;

  // R2: read and write strobes never overlap
  p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  // R2: a read strobe ends only after its sampling cycle or an abort
  p_strobe_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd) |-> ($past(strobe_last) || $past(abort)));
  // R6: the reset write is always followed by a failing report
  p_wr_then_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (done && !pass));
  // R8: done is a single pulse while busy, and busy ends with it
  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R9: abort during the read phase ends the poll at once
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && (state_q == ST_READ || state_q == ST_GAP)) |=> (!busy && !bus_wr));
endmodule

// File: tb/test_toggle_poll_ctrl.sv
module test_toggle_poll_ctrl;
  localparam int RD_CYC = 3;
  localparam int MAXP   = 4;
  localparam logic [15:0] SA = 16'h0AAA;
  localparam logic [15:0] RA = 16'h0555;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic abort = 1'b0;
  logic [15:0] bus_addr;
  logic bus_rd, bus_wr, busy, done, pass;
  logic [7:0] bus_wdata, bus_rdata;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  toggle_poll_ctrl #(.AW(16), .STAT_ADDR(SA), .RST_ADDR(RA),
                     .RD_CYC(RD_CYC), .MAX_PAIRS(MAXP)) i_toggle_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .pass(pass));

  // flash status model and bus monitor
  logic [7:0] script [0:15];
  logic clr_mon = 1'b0;
  logic rd_prev;
  int idx, rd_run, reads, writes, dones, bad_runs, bad_addr, bad_wr;

  assign bus_rdata = (bus_rd && rd_run == RD_CYC - 1) ? script[idx] : ~script[idx];

  always @(posedge clk) begin
    if (clr_mon) begin
      idx <= 0; rd_run <= 0; reads <= 0; writes <= 0; dones <= 0;
      bad_runs <= 0; bad_addr <= 0; bad_wr <= 0; rd_prev <= bus_rd;
    end else begin
      rd_prev <= bus_rd;
      if (bus_rd) begin
        rd_run <= rd_run + 1;
        if (bus_addr != SA) bad_addr <= bad_addr + 1;
        if (!rd_prev) reads <= reads + 1;
      end else begin
        rd_run <= 0;
        if (rd_prev) begin
          if (rd_run != RD_CYC && !abort) bad_runs <= bad_runs + 1;
          if (idx < 15) idx <= idx + 1;
        end
      end
      if (bus_wr) begin
        writes <= writes + 1;
        if (bus_addr != RA || bus_wdata != 8'hF0) bad_wr <= bad_wr + 1;
      end
      if (done) dones <= dones + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk) clr_mon = 1'b1;
    @(negedge clk) clr_mon = 1'b0;
  endtask

  // start a poll and wait for done; checks busy timing on the way
  task automatic run_poll(output bit got_pass, output bit seen);
    seen = 1'b0;
    got_pass = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    for (int i = 0; i < 3000; i++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    if (seen) begin
      got_pass = pass;
      chk(busy == 1'b1, "R8 busy during done", busy, 1);
      @(negedge clk);
      chk(!done && !busy, "R8 done single and busy drops", {done, busy}, 0);
    end
  endtask

  task automatic load4(input logic [7:0] a, b, c, d);
    for (int i = 0; i < 16; i++) script[i] = 8'h00;
    script[0] = a; script[1] = b; script[2] = c; script[3] = d;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !pass && !bus_rd && !bus_wr, "R1 reset state",
        {busy, done, pass, bus_rd, bus_wr}, 0);
  endtask

  task automatic t_steady();
    bit p, s;
    load4(8'h40, 8'h40, 8'h00, 8'h00);
    clear_mon();
    run_poll(p, s);
    chk(s && p, "R3 steady pass", {s, p}, 3);
    chk(reads == 2 && writes == 0, "R3 two reads no write", reads * 10 + writes, 20);
    chk(bad_runs == 0 && bad_addr == 0, "R2 strobe width and address", bad_runs + bad_addr, 0);
  endtask

  task automatic t_keep_polling();
    bit p, s;
    load4(8'h00, 8'h40, 8'h10, 8'h10);
    clear_mon();
    run_poll(p, s);
    chk(s && p, "R4 pass after second pair", {s, p}, 3);
    chk(reads == 4 && writes == 0, "R4 four reads", reads * 10 + writes, 40);
    chk(bad_runs == 0, "R2 strobe width", bad_runs, 0);
  endtask

  task automatic t_late_stop();
    bit p, s;
    load4(8'h00, 8'h60, 8'h60, 8'h60);
    clear_mon();
    run_poll(p, s);
    chk(s && p, "R5 confirm pair passes", {s, p}, 3);
    chk(reads == 4 && writes == 0, "R5 no reset write", reads * 10 + writes, 40);
  endtask

  task automatic t_late_fail();
    bit p, s;
    load4(8'h00, 8'h60, 8'h20, 8'h60);
    clear_mon();
    run_poll(p, s);
    chk(s && !p, "R6 confirm pair fails", {s, p}, 2);
    chk(reads == 4 && writes == 1, "R6 one reset write", reads * 10 + writes, 41);
    chk(bad_wr == 0, "R6 reset write address and data", bad_wr, 0);
  endtask

  task automatic t_watchdog();
    bit p, s;
    for (int i = 0; i < 16; i++) script[i] = (i % 2 == 0) ? 8'h00 : 8'h40;
    clear_mon();
    run_poll(p, s);
    chk(s && !p, "R7 pair limit fails", {s, p}, 2);
    chk(reads == 2 * MAXP && writes == 1, "R7 read count and write", reads * 10 + writes, 20 * MAXP + 1);
  endtask

  task automatic t_abort();
    bit p, s;
    load4(8'h40, 8'h00, 8'h00, 8'h00);
    clear_mon();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 100 && reads < 2; i++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk(!busy, "R9 busy low after abort", busy, 0);
    repeat (8) @(negedge clk);
    chk(dones == 0 && writes == 0, "R9 no done no write", dones * 10 + writes, 0);
    load4(8'h00, 8'h00, 8'h40, 8'h40);
    clear_mon();
    run_poll(p, s);
    chk(s && p, "R9 restart passes", {s, p}, 3);
    chk(reads == 2, "R9 fresh pair on restart", reads, 2);
  endtask

  task automatic t_idle_abort();
    clear_mon();
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && reads == 0 && dones == 0 && writes == 0, "R10 idle abort ignored",
        busy + reads + dones + writes, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) script[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_steady();
    t_keep_polling();
    t_late_stop();
    t_late_fail();
    t_watchdog();
    t_abort();
    t_idle_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule